// File: doc/BRIEF.md
# Serial Command Decoder with Toggle Configuration

This block sits between a host microcontroller and the telephone front end's tone generators and audio path. The host sends short command words over a two-line link made of a clock line and a data line. The block finds where each frame starts and collects the bits. It classifies each complete word and updates a small set of control registers. Those registers set the operating mode, the tone digit in use, the ringer loudness and four configuration flags that flip on each reception.

The serial lines are sampled with the system clock, so the host's transitions must be slower than a few system clock periods. A digit code is only held as a pending value. It reaches the tone output when the dial command arrives. A reset command returns everything to defaults and pulls the reset status line low. After that the block refuses all commands until the hook-cycle input pulses. A separate initialise command restores defaults and leaves the status line high.

Top module: `sercmd_decoder`

## Requirements
- R1: A frame starts when `ser_dat` changes while `ser_clk` is high. Bits a0 then a5 arrive in that order, each one taken at a rising edge of `ser_clk`. The word is acted on at the falling edge that follows the sixth bit and no earlier. Any further bits in the same frame (for example a6 and a7 of an eight-bit word) are ignored. A new start condition in the middle of a frame discards the partial word. Codes below are written a5 first.
- R2: After `rst` the outputs are: `op_mode`=0 (talk), `tone_code`=0, `ring_level`=3, `agc_on`=1, `mask_on`=0, `rx_boost`=0, `osc_internal`=0, and `rst_status_n`=1.
- R3: A code 00dddd stores dddd as a pending digit and leaves `tone_code` unchanged. Code 010001 sets `op_mode`=1 (dial) and copies the pending digit to `tone_code`.
- R4: Code 010000 sets `op_mode`=0. Code 010010 sets `op_mode`=2 (earpiece and microphone muted). Code 010011 sets `op_mode`=3 (microphone muted).
- R5: Four codes each invert one flag: 010100 inverts `agc_on`, 010101 inverts `mask_on`, 010110 inverts `rx_boost` and 101000 inverts `osc_internal`. Receiving the same code twice restores the flag.
- R6: Code 0111LL sets `ring_level`=LL, where 0 is the quietest step and 3 the loudest.
- R7: Code 010111 received in talk mode restores the R2 values except that `rst_status_n` goes to 0. After that every command is ignored until `hook_evt` is seen.
- R8: Code 010111 received in any mode other than talk changes nothing.
- R9: Code 111010 restores the R2 values and keeps `rst_status_n` at 1.
- R10: A one-cycle `hook_evt` pulse restores the R2 values, sets `rst_status_n` to 1 and lifts the lockout of R7.
- R11: A word that matches none of the codes above (for example 011000, 111111 or 100000) changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock line from the host |
| ser_dat | input | 1 | Serial data line from the host |
| hook_evt | input | 1 | One-cycle pulse marking an on-hook/off-hook cycle |
| op_mode | output | 2 | 0 talk, 1 dial, 2 full mute, 3 microphone mute |
| tone_code | output | 4 | Digit code in use by the tone generator |
| ring_level | output | 2 | Ringer loudness step, 0 quietest |
| agc_on | output | 1 | Line-length gain control enabled |
| mask_on | output | 1 | Low-voltage make masking enabled |
| rx_boost | output | 1 | Receive channel +6 dB enabled |
| osc_internal | output | 1 | Internal oscillator selected instead of external clock |
| rst_status_n | output | 1 | Active-low reset status to the host |

## Verification
The bench builds the block with its default word width of six bits. The bit counter therefore saturates at six. Eight-bit words then show that a6 and a7 fall past the decode point and never disturb the state. The same width puts the restart-in-mid-frame case and the exact decode edge within reach. The bench holds its comparison open through the sixth rising edge and closes it only when the final falling edge is driven.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;

    localparam int CODE_W = 6;

    typedef enum logic [1:0] {
        MODE_TALK     = 2'd0,
        MODE_DIAL     = 2'd1,
        MODE_MUTE_ALL = 2'd2,
        MODE_MUTE_MIC = 2'd3
    } op_mode_e;

    typedef enum logic [3:0] {
        K_NONE,
        K_STORE_TONE,
        K_TALK,
        K_DIAL,
        K_MUTE_ALL,
        K_MUTE_MIC,
        K_TOG_MASK,
        K_TOG_AGC,
        K_TOG_BOOST,
        K_TOG_OSC,
        K_RING_LVL,
        K_LOCK_RST,
        K_INIT
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e  kind;
        logic [3:0] arg;
    } cmd_t;

    typedef struct packed {
        op_mode_e   mode;
        logic [3:0] pend;
        logic [3:0] tone;
        logic [1:0] ring;
        logic       agc;
        logic       mask;
        logic       boost;
        logic       osc;
    } ctl_state_t;

    function automatic ctl_state_t ctl_default();
        ctl_state_t s;
        s.mode  = MODE_TALK;
        s.pend  = 4'd0;
        s.tone  = 4'd0;
        s.ring  = 2'd3;
        s.agc   = 1'b1;
        s.mask  = 1'b0;
        s.boost = 1'b0;
        s.osc   = 1'b0;
        return s;
    endfunction

    // w[i] holds bit a_i; literals are written a5 first.
    function automatic cmd_t classify(logic [CODE_W-1:0] w);
        cmd_t r;
        r.kind = K_NONE;
        r.arg  = w[3:0];
        casez (w)
            6'b00????: r.kind = K_STORE_TONE;
            6'b010000: r.kind = K_TALK;
            6'b010001: r.kind = K_DIAL;
            6'b010010: r.kind = K_MUTE_ALL;
            6'b010011: r.kind = K_MUTE_MIC;
            6'b010100: r.kind = K_TOG_AGC;
            6'b010101: r.kind = K_TOG_MASK;
            6'b010110: r.kind = K_TOG_BOOST;
            6'b010111: r.kind = K_LOCK_RST;
            6'b0111??: r.kind = K_RING_LVL;
            6'b101000: r.kind = K_TOG_OSC;
            6'b111010: r.kind = K_INIT;
            default:   r.kind = K_NONE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sercmd_frame_rx.sv
module sercmd_frame_rx #(
    parameter int WORD_BITS = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    output logic [WORD_BITS-1:0] word_o,
    output logic                 fire_o
);
    localparam int CNT_W = $clog2(WORD_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_BITS);

    logic s_clk, s_dat, p_clk, p_dat;
    logic armed;
    logic [CNT_W-1:0] cnt;
    logic [WORD_BITS-1:0] shreg;

    logic rise, fall, start;
    assign rise  = s_clk & ~p_clk;
    assign fall  = ~s_clk & p_clk;
    assign start = s_clk & p_clk & (s_dat ^ p_dat);

    always_ff @(posedge clk) begin
        if (rst) begin
            s_clk <= 1'b0;
            s_dat <= 1'b0;
            p_clk <= 1'b0;
            p_dat <= 1'b0;
            armed <= 1'b0;
            cnt   <= '0;
            shreg <= '0;
        end else begin
            s_clk <= ser_clk;
            s_dat <= ser_dat;
            p_clk <= s_clk;
            p_dat <= s_dat;
            if (start) begin
                armed <= 1'b1;
                cnt   <= '0;
            end else if (rise && armed && cnt < FULL) begin
                shreg[cnt] <= s_dat;
                cnt        <= cnt + 1'b1;
            end else if (fall && armed && cnt == FULL) begin
                armed <= 1'b0;
            end
        end
    end

    assign fire_o = fall & armed & (cnt == FULL);
    assign word_o = shreg;
endmodule

// File: rtl/sercmd_ctl_regs.sv
module sercmd_ctl_regs
    import sercmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hook_evt,
    input  logic       fire,
    input  cmd_t       cmd,
    output ctl_state_t st,
    output logic       status_n
);
    logic locked;

    always_ff @(posedge clk) begin
        if (rst || hook_evt) begin
            st       <= ctl_default();
            status_n <= 1'b1;
            locked   <= 1'b0;
        end else if (fire && !locked) begin
            case (cmd.kind)
                K_STORE_TONE: st.pend <= cmd.arg;
                K_TALK:       st.mode <= MODE_TALK;
                K_DIAL: begin
                    st.mode <= MODE_DIAL;
                    st.tone <= st.pend;
                end
                K_MUTE_ALL:   st.mode  <= MODE_MUTE_ALL;
                K_MUTE_MIC:   st.mode  <= MODE_MUTE_MIC;
                K_TOG_AGC:    st.agc   <= ~st.agc;
                K_TOG_MASK:   st.mask  <= ~st.mask;
                K_TOG_BOOST:  st.boost <= ~st.boost;
                K_TOG_OSC:    st.osc   <= ~st.osc;
                K_RING_LVL:   st.ring  <= cmd.arg[1:0];
                K_LOCK_RST: begin
                    if (st.mode == MODE_TALK) begin
                        st       <= ctl_default();
                        status_n <= 1'b0;
                        locked   <= 1'b1;
                    end
                end
                K_INIT:       st <= ctl_default();
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sercmd_decoder.sv
module sercmd_decoder
    import sercmd_pkg::*;
#(
    parameter int WORD_BITS = CODE_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ser_clk,
    input  logic       ser_dat,
    input  logic       hook_evt,
    output logic [1:0] op_mode,
    output logic [3:0] tone_code,
    output logic [1:0] ring_level,
    output logic       agc_on,
    output logic       mask_on,
    output logic       rx_boost,
    output logic       osc_internal,
    output logic       rst_status_n
);
    logic [WORD_BITS-1:0] word;
    logic                 cmd_fire;
    cmd_t                 cmd;
    ctl_state_t           st;

    sercmd_frame_rx #(.WORD_BITS(WORD_BITS)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .ser_clk (ser_clk),
        .ser_dat (ser_dat),
        .word_o  (word),
        .fire_o  (cmd_fire)
    );

    assign cmd = classify(word[CODE_W-1:0]);

    sercmd_ctl_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .hook_evt (hook_evt),
        .fire     (cmd_fire),
        .cmd      (cmd),
        .st       (st),
        .status_n (rst_status_n)
    );

    assign op_mode      = st.mode;
    assign tone_code    = st.tone;
    assign ring_level   = st.ring;
    assign agc_on       = st.agc;
    assign mask_on      = st.mask;
    assign rx_boost     = st.boost;
    assign osc_internal = st.osc;
endmodule

// File: rtl/sercmd_decoder_chk.sv
module sercmd_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       hook_evt,
    input logic       cmd_fire,
    input logic [1:0] op_mode,
    input logic [3:0] tone_code,
    input logic [1:0] ring_level,
    input logic       agc_on,
    input logic       mask_on,
    input logic       rx_boost,
    input logic       osc_internal,
    input logic       rst_status_n
);
    logic [12:0] snap;
    assign snap = {op_mode, tone_code, ring_level, agc_on, mask_on,
                   rx_boost, osc_internal, rst_status_n};

    // R1: state moves only on a completed frame or a hook event
    p_quiet_hold_r1: assert property (@(posedge clk) disable iff (rst)
        (!cmd_fire && !hook_evt) |=> $stable(snap));

    // R7: while locked out nothing changes until a hook event
    p_lock_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!rst_status_n && !hook_evt) |=> $stable(snap));

    // R7: entering lockout leaves every field at its default
    p_lock_entry_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_status_n) |-> (op_mode == 2'd0 && tone_code == 4'd0 &&
            ring_level == 2'd3 && agc_on && !mask_on && !rx_boost && !osc_internal));

    // R10: a hook event restores defaults and releases the status line
    p_hook_release_r10: assert property (@(posedge clk) disable iff (rst)
        hook_evt |=> (rst_status_n && op_mode == 2'd0 && agc_on && !mask_on));

    // R3: the tone output only moves when dialing or back to default
    p_tone_dial_r3: assert property (@(posedge clk) disable iff (rst)
        !$stable(tone_code) |-> (op_mode == 2'd1 || tone_code == 4'd0));
endmodule

bind sercmd_decoder sercmd_decoder_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .hook_evt     (hook_evt),
    .cmd_fire     (cmd_fire),
    .op_mode      (op_mode),
    .tone_code    (tone_code),
    .ring_level   (ring_level),
    .agc_on       (agc_on),
    .mask_on      (mask_on),
    .rx_boost     (rx_boost),
    .osc_internal (osc_internal),
    .rst_status_n (rst_status_n)
);

// File: tb/sercmd_decoder_test.sv
`timescale 1ns/1ps
module sercmd_decoder_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b0;
    logic ser_dat = 1'b0;
    logic hook_evt = 1'b0;
    logic [1:0] op_mode;
    logic [3:0] tone_code;
    logic [1:0] ring_level;
    logic agc_on, mask_on, rx_boost, osc_internal, rst_status_n;

    always #2 clk = ~clk;

    sercmd_decoder uut (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .hook_evt(hook_evt), .op_mode(op_mode), .tone_code(tone_code),
        .ring_level(ring_level), .agc_on(agc_on), .mask_on(mask_on),
        .rx_boost(rx_boost), .osc_internal(osc_internal),
        .rst_status_n(rst_status_n)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit cmp_en = 1'b0;

    // behavioural reference state
    int m_mode, m_pend, m_tone, m_ring, m_agc, m_mask, m_boost, m_osc, m_stat;
    bit m_lock;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            if (fails < 40) $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic m_defaults();
        m_mode = 0; m_pend = 0; m_tone = 0; m_ring = 3;
        m_agc = 1; m_mask = 0; m_boost = 0; m_osc = 0;
    endtask

    task automatic m_apply(int c);
        if (m_lock) return;
        if (c < 16) m_pend = c;
        else if (c == 'b010000) m_mode = 0;
        else if (c == 'b010001) begin m_mode = 1; m_tone = m_pend; end
        else if (c == 'b010010) m_mode = 2;
        else if (c == 'b010011) m_mode = 3;
        else if (c == 'b010100) m_agc = 1 - m_agc;
        else if (c == 'b010101) m_mask = 1 - m_mask;
        else if (c == 'b010110) m_boost = 1 - m_boost;
        else if (c == 'b101000) m_osc = 1 - m_osc;
        else if (c >= 'b011100 && c <= 'b011111) m_ring = c - 'b011100;
        else if (c == 'b010111) begin
            if (m_mode == 0) begin m_defaults(); m_stat = 0; m_lock = 1; end
        end
        else if (c == 'b111010) m_defaults();
    endtask

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            check("R4 op_mode", int'(op_mode), m_mode);
            check("R3 tone_code", int'(tone_code), m_tone);
            check("R6 ring_level", int'(ring_level), m_ring);
            check("R5 agc_on", int'(agc_on), m_agc);
            check("R5 mask_on", int'(mask_on), m_mask);
            check("R5 rx_boost", int'(rx_boost), m_boost);
            check("R5 osc_internal", int'(osc_internal), m_osc);
            check("R7 rst_status_n", int'(rst_status_n), m_stat);
        end
    end

    task automatic line(logic c, logic d);
        @(negedge clk);
        ser_clk = c;
        ser_dat = d;
        repeat (3) @(negedge clk);
    endtask

    task automatic start_cond();
        line(1'b1, ser_dat);
        line(1'b1, ~ser_dat);
        line(1'b0, ser_dat);
    endtask

    // R1: sends nb bits a0 first; state must hold until the fall after bit six
    task automatic send(logic [7:0] w, int nb);
        start_cond();
        for (int i = 0; i < nb; i++) begin
            line(1'b0, w[i]);
            line(1'b1, w[i]);
            if (i == 5) begin
                cmp_en = 1'b0;
                line(1'b0, w[i]);
                m_apply(int'(w[5:0]));
                cmp_en = 1'b1;
            end else begin
                line(1'b0, w[i]);
            end
        end
    endtask

    task automatic cmd6(logic [5:0] c);
        send({2'b00, c}, 6);
    endtask

    task automatic hook();
        @(negedge clk);
        cmp_en   = 1'b0;
        hook_evt = 1'b1;
        @(negedge clk);
        hook_evt = 1'b0;
        m_defaults(); m_stat = 1; m_lock = 0;
        @(negedge clk);
        cmp_en = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL R1 watchdog act=0 exp=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_defaults(); m_stat = 1; m_lock = 0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        check("R2 op_mode", int'(op_mode), 0);
        check("R2 tone_code", int'(tone_code), 0);
        check("R2 ring_level", int'(ring_level), 3);
        check("R2 agc_on", int'(agc_on), 1);
        check("R2 mask_on", int'(mask_on), 0);
        check("R2 rx_boost", int'(rx_boost), 0);
        check("R2 osc_internal", int'(osc_internal), 0);
        check("R2 rst_status_n", int'(rst_status_n), 1);
        cmp_en = 1'b1;

        // R3 pending digit then dial
        cmd6(6'b000101);
        check("R3 tone held", int'(tone_code), 0);
        cmd6(6'b010001);
        check("R3 dial mode", int'(op_mode), 1);
        check("R3 tone copy", int'(tone_code), 5);
        cmd6(6'b001010);
        check("R3 tone held in dial", int'(tone_code), 5);
        cmd6(6'b010000);
        cmd6(6'b010001);
        check("R3 second digit", int'(tone_code), 10);

        // R4 operating modes
        cmd6(6'b010010);
        check("R4 full mute", int'(op_mode), 2);
        cmd6(6'b010011);
        check("R4 mic mute", int'(op_mode), 3);
        cmd6(6'b010000);
        check("R4 talk", int'(op_mode), 0);

        // R5 each toggle twice
        cmd6(6'b010110);
        check("R5 boost on", int'(rx_boost), 1);
        cmd6(6'b010110);
        check("R5 boost restored", int'(rx_boost), 0);
        cmd6(6'b010100); cmd6(6'b010100);
        check("R5 agc restored", int'(agc_on), 1);
        cmd6(6'b010101);
        check("R5 mask on", int'(mask_on), 1);
        cmd6(6'b010101);
        cmd6(6'b101000);
        check("R5 osc on", int'(osc_internal), 1);
        cmd6(6'b101000);

        // R6 ring levels
        for (int l = 0; l < 4; l++) begin
            cmd6(6'b011100 | 6'(l));
            check("R6 ring level", int'(ring_level), l);
        end

        // R1 eight-bit word, a6/a7 ignored
        send(8'b11_010100, 8);
        check("R1 eight-bit word agc", int'(agc_on), 0);
        send(8'b10_010100, 8);
        check("R1 eight-bit word agc back", int'(agc_on), 1);

        // R1 restart in mid frame discards partial bits
        start_cond();
        for (int i = 0; i < 3; i++) begin
            line(1'b0, 1'b1); line(1'b1, 1'b1); line(1'b0, 1'b1);
        end
        cmd6(6'b010110);
        check("R1 resync boost", int'(rx_boost), 1);
        cmd6(6'b010110);

        // R11 unrecognised words
        cmd6(6'b011000); cmd6(6'b111111); cmd6(6'b100000);
        check("R11 mode kept", int'(op_mode), 0);
        check("R11 agc kept", int'(agc_on), 1);

        // R8 reset code outside talk mode
        cmd6(6'b010001);
        cmd6(6'b010111);
        check("R8 status high", int'(rst_status_n), 1);
        check("R8 mode kept", int'(op_mode), 1);
        cmd6(6'b010000);

        // R9 initialise
        cmd6(6'b010110); cmd6(6'b011101); cmd6(6'b101000);
        cmd6(6'b111010);
        check("R9 boost default", int'(rx_boost), 0);
        check("R9 ring default", int'(ring_level), 3);
        check("R9 status high", int'(rst_status_n), 1);

        // R7 reset code in talk mode and lockout
        cmd6(6'b010101);
        cmd6(6'b010111);
        check("R7 status low", int'(rst_status_n), 0);
        check("R7 mask default", int'(mask_on), 0);
        cmd6(6'b010100);
        check("R7 agc locked", int'(agc_on), 1);
        cmd6(6'b011100);
        check("R7 ring locked", int'(ring_level), 3);

        // R10 hook cycle releases
        hook();
        check("R10 status high", int'(rst_status_n), 1);
        cmd6(6'b010100);
        check("R10 agc after release", int'(agc_on), 0);

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule